// File: doc/BRIEF.md
# Single-Bus Register File with Swap Sequencer

This block holds four general-purpose registers and one hidden scratch register, all joined by a single shared bus. A five-way source multiplexer places one register on the bus, and every register has its own load enable. Because only one value can cross the bus in a clock, a small control sequencer breaks each command into bus transfers. A command either copies one register into another or exchanges two registers.

A copy uses one bus state. An exchange uses three bus states and routes the first value through the scratch register. The sequencer shows `busy` while it owns the bus and gives a one-cycle `done` pulse when the work is complete. The register values can be read directly on a flat output vector so that the contents can be checked.

Top module: `busreg_swap`

## Requirements
- R1: After reset, general register k holds INIT_BASE + k*INIT_STEP (defaults 8'h11, 8'h33, 8'h55, 8'h77 for k = 0..3), and `busy` and `done` are low.
- R2: A command is accepted when `cmd_valid` is high at a clock edge and the block is idle. `cmd_op` = 0 means copy `cmd_a` into `cmd_b`. `cmd_op` = 1 means exchange `cmd_a` with `cmd_b`.
- R3: A copy takes one bus state, in which `busy` is high. Register `cmd_b` takes the value of register `cmd_a`, and no other general register changes.
- R4: An exchange takes three successive bus states with `busy` high. The states are: `cmd_a` to scratch, then `cmd_b` to `cmd_a`, then scratch to `cmd_b`. In the first state `bus_sel` equals `cmd_a` and only load enable bit 4 is set.
- R5: A `bus_sel` value of k (0..4) places register k on `bus_data`, where 4 is the scratch register. At most one load enable bit is high in any cycle. A register whose enable is high takes the bus value at the closing edge of that cycle.
- R6: `done` is high for exactly one cycle, in the cycle after the last load. `busy` is low in that cycle.
- R7: A command presented while `busy` is high is ignored. It causes no transfer, either during the current command or after it.
- R8: Exchanging a register with itself, or copying a register onto itself, completes normally and leaves every general register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = copy, 1 = exchange |
| cmd_a | input | 2 | First register index (copy source) |
| cmd_b | input | 2 | Second register index (copy destination) |
| busy | output | 1 | Sequencer owns the bus |
| done | output | 1 | One-cycle completion pulse |
| bus_sel | output | 3 | Current bus source select |
| load_en | output | 5 | Per-register load enables, bit 4 = scratch |
| bus_data | output | W | Value on the shared bus |
| regs_out | output | 4*W | General registers, R0 in the low bits |

## Verification
The hardest case to reach is a command that arrives during the middle of an exchange. The bench starts an exchange and, one cycle later, while `busy` is high, strobes a copy that would corrupt the exchanged registers. It then checks that the exchange result is intact, and that no extra busy cycle follows `done`. Self-exchange is also driven, so the scratch detour is exercised when source and destination are the same register.

// File: rtl/busreg_swap.sv
module busreg_swap #(
  parameter int W         = 8,
  parameter int INIT_BASE = 'h11,
  parameter int INIT_STEP = 'h22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic           cmd_op,
  input  logic [1:0]     cmd_a,
  input  logic [1:0]     cmd_b,
  output logic           busy,
  output logic           done,
  output logic [2:0]     bus_sel,
  output logic [4:0]     load_en,
  output logic [W-1:0]   bus_data,
  output logic [4*W-1:0] regs_out
);
  localparam int NREG = 5;
  localparam logic [2:0] TMP = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_MOVE, S_X0, S_X1, S_X2} state_t;
  state_t state;
  logic [1:0] a_q, b_q;
  logic [W-1:0] r [NREG];

  assign busy = (state != S_IDLE);

  always_comb begin
    bus_sel = 3'd0;
    load_en = '0;
    case (state)
      S_MOVE: begin bus_sel = {1'b0, a_q}; load_en[b_q] = 1'b1; end
      S_X0:   begin bus_sel = {1'b0, a_q}; load_en[TMP] = 1'b1; end
      S_X1:   begin bus_sel = {1'b0, b_q}; load_en[a_q] = 1'b1; end
      S_X2:   begin bus_sel = TMP;         load_en[b_q] = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (bus_sel)
      3'd0: bus_data = r[0];
      3'd1: bus_data = r[1];
      3'd2: bus_data = r[2];
      3'd3: bus_data = r[3];
      default: bus_data = r[4];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == S_MOVE) || (state == S_X2);
      case (state)
        S_IDLE: if (cmd_valid) begin
          a_q   <= cmd_a;
          b_q   <= cmd_b;
          state <= cmd_op ? S_X0 : S_MOVE;
        end
        S_X0:   state <= S_X1;
        S_X1:   state <= S_X2;
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          r[k] <= W'(INIT_BASE + k * INIT_STEP);
      else if (load_en[k]) r[k] <= bus_data;
    end
    if (k < 4) begin : g_out
      assign regs_out[k*W +: W] = r[k];
    end
    a_r5_load_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
      load_en[k] |=> (r[k] == $past(bus_data)));
  end

  a_r5_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_en));
  a_r5_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel <= TMP);
  a_r4_tmp_then_restore: assert property (@(posedge clk) disable iff (!rst_n)
    load_en[4] |=> (busy && !load_en[4] && bus_sel != TMP));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (load_en == 5'b0));
endmodule

// File: tb/busreg_swap_bench.sv
module busreg_swap_bench;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_op = 0;
  logic [1:0] cmd_a = 0, cmd_b = 0;
  logic busy, done;
  logic [2:0] bus_sel;
  logic [4:0] load_en;
  logic [W-1:0] bus_data;
  logic [4*W-1:0] regs_out;
  int tests = 0, fails = 0;
  logic [W-1:0] m [4];

  always #10 clk = ~clk;

  busreg_swap #(.W(W)) u_busreg_swap (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    for (int k = 0; k < 4; k++) chk(req, regs_out[k*W +: W], m[k]);
  endtask

  task automatic run_cmd(string req, logic op, logic [1:0] a, logic [1:0] b,
                         int exp_cyc, bit intrude);
    int cyc = 0;
    logic [2:0] s0;
    logic [4:0] l0;
    logic [W-1:0] t;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 0;
    s0 = bus_sel; l0 = load_en;
    if (intrude) begin
      cmd_valid = 1; cmd_op = 0; cmd_a = b; cmd_b = a;
    end
    while (!done && cyc < 20) begin
      if (busy) cyc++;
      @(negedge clk);
      cmd_valid = 0;
    end
    chk({req, " busy cycles"}, cyc, exp_cyc);
    chk("R6 busy low with done", busy, 0);
    if (op) begin
      chk("R4 first sel", s0, {1'b0, a});
      chk("R4 first load", l0, 5'b10000);
      t = m[a]; m[a] = m[b]; m[b] = t;
    end else begin
      m[b] = m[a];
    end
    chk_regs(req);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R7 no late start", busy, 0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m[k] = W'('h11 + k * 'h22);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_regs("R1 reset values");
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    run_cmd("R3 copy 0->2", 0, 2'd0, 2'd2, 1, 0);
    run_cmd("R3 copy 3->1", 0, 2'd3, 2'd1, 1, 0);
    run_cmd("R2 copy 1->0", 0, 2'd1, 2'd0, 1, 0);
    run_cmd("R4 swap 1,2", 1, 2'd1, 2'd2, 3, 0);
    run_cmd("R4 swap 3,0", 1, 2'd3, 2'd0, 3, 0);
    run_cmd("R7 swap with intruder", 1, 2'd0, 2'd1, 3, 1);
    run_cmd("R8 swap self", 1, 2'd2, 2'd2, 3, 0);
    run_cmd("R8 copy self", 0, 2'd3, 2'd3, 1, 0);
    run_cmd("R4 swap 2,3", 1, 2'd2, 2'd3, 3, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule